// File: doc/BRIEF.md
# Exception Priority and Vector Selector

This block sits beside a processor pipeline and turns a set of exception request lines into a single, registered "take" event. In each clock cycle it looks at everything pending: the boot event after reset, data and prefetch aborts, undefined-instruction and software-interrupt requests, and the fast and normal interrupt lines. From these it picks exactly one by a fixed priority. It then emits a one-cycle strobe that carries a 3-bit exception code and the 32-bit program-counter vector the pipeline must jump to.

Abort, undefined and software-interrupt requests arrive as one-cycle pulses. A pulse that loses arbitration is latched and taken in a later cycle. The two interrupt lines are level-sensitive and are gated by disable flags, which the block keeps itself. Taking a fast interrupt blocks both interrupt kinds. Taking a normal interrupt blocks only normal interrupts. Return strobes and software re-enable inputs clear the flags. The fast-interrupt return puts the normal-interrupt flag back to the value it had before the fast interrupt was taken.

A relocation input moves every vector except the reset vector up to a high base. The take strobe has no back-pressure: the pipeline must accept it in the cycle it appears. At most one take is issued per cycle. Pending events keep the selector busy on consecutive cycles until they are drained.

Top module: `exc_vector_sel`

## Requirements
- R1: While rst_n is low, o_take, o_fiq_off and o_irq_off are 0 at once, without waiting for a clock edge. On the first rising clock edge after rst_n goes high, o_take is 1 with o_code 0 and o_vec 0x00000000, whatever i_high_vec holds.
- R2: When several exceptions are eligible in the same cycle, only the highest-priority one is taken, and at most one take occurs per cycle. The order from highest to lowest is: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R3: The code values are: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, normal interrupt 6, fast interrupt 7. With i_high_vec low, o_vec equals 4 times o_code.
- R4: With i_high_vec high in the selecting cycle, o_vec equals 0xFFFF0000 plus 4 times o_code for every exception except reset.
- R5: A pulse request that is not taken in its own cycle stays pending and is taken later in priority order. When an undefined request and a software-interrupt request are both pending, the undefined one is taken first.
- R6: Taking a fast interrupt sets both o_fiq_off and o_irq_off. No normal interrupt is taken while o_fiq_off or o_irq_off is 1. A pulse on i_fiq_ret clears o_fiq_off and returns o_irq_off to its value just before that fast interrupt was taken.
- R7: Taking a normal interrupt sets o_irq_off only. A pulse on i_irq_ret or i_irq_reen clears o_irq_off. A pulse on i_fiq_reen clears o_fiq_off. A take in the same cycle wins over a clear.
- R8: An interrupt line that is held high is taken once. It is not taken again until its disable flag has been cleared.
- R9: i_req_undef and i_req_swi are never high in the same cycle; an assertion reports a violation. When they arrive in consecutive cycles, both are taken.
- R10: o_take, o_code and o_vec are registered and valid in the same cycle. A request seen before clock edge N is reported after edge N at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_high_vec | input | 1 | Relocates non-reset vectors to the high base |
| i_req_dabort | input | 1 | Data abort request pulse |
| i_req_fiq | input | 1 | Fast interrupt request level |
| i_req_irq | input | 1 | Normal interrupt request level |
| i_req_pabort | input | 1 | Prefetch abort request pulse |
| i_req_undef | input | 1 | Undefined instruction request pulse |
| i_req_swi | input | 1 | Software interrupt request pulse |
| i_fiq_ret | input | 1 | Fast handler return strobe |
| i_irq_ret | input | 1 | Normal handler return strobe |
| i_fiq_reen | input | 1 | Software re-enable of fast interrupts |
| i_irq_reen | input | 1 | Software re-enable of normal interrupts |
| o_take | output | 1 | One-cycle take strobe |
| o_code | output | 3 | Code of the taken exception |
| o_vec | output | 32 | Vector of the taken exception |
| o_fiq_off | output | 1 | Fast interrupt disable flag |
| o_irq_off | output | 1 | Normal interrupt disable flag |

## Verification
The hardest state to reach is one where the normal-interrupt flag has to be restored across a fast-interrupt handler. That needs a normal take, then a fast take on top of it, then a fast return, and it has to be told apart from the case where the normal flag was clear before the fast take. Directed sequences build both histories from a fresh reset and check the flag and the later take. A sweep over every legal single-cycle mix of requests, under both vector bases, fills the pending latches all at once. It then checks that they drain in priority order, one per cycle, and that interrupts held high are taken only once.

// File: rtl/exc_sel_pkg.sv
`timescale 1ns/1ps
package exc_sel_pkg;
  localparam int CODE_W = 3;
  localparam int NSRC   = 7;   // arbitration slots
  localparam int NPULSE = 4;   // latched pulse sources

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET  = 3'd0,
    EXC_UNDEF  = 3'd1,
    EXC_SWI    = 3'd2,
    EXC_PABORT = 3'd3,
    EXC_DABORT = 3'd4,
    EXC_IRQ    = 3'd6,
    EXC_FIQ    = 3'd7
  } exc_code_e;

  // Arbitration slots, lowest index wins
  localparam int SLOT_RESET  = 0;
  localparam int SLOT_DABORT = 1;
  localparam int SLOT_FIQ    = 2;
  localparam int SLOT_IRQ    = 3;
  localparam int SLOT_PABORT = 4;
  localparam int SLOT_UNDEF  = 5;
  localparam int SLOT_SWI    = 6;

  // Pulse latch lanes
  localparam int PL_DABORT = 0;
  localparam int PL_PABORT = 1;
  localparam int PL_UNDEF  = 2;
  localparam int PL_SWI    = 3;

  function automatic exc_code_e slot_code(input int slot);
    case (slot)
      SLOT_DABORT: return EXC_DABORT;
      SLOT_FIQ:    return EXC_FIQ;
      SLOT_IRQ:    return EXC_IRQ;
      SLOT_PABORT: return EXC_PABORT;
      SLOT_UNDEF:  return EXC_UNDEF;
      SLOT_SWI:    return EXC_SWI;
      default:     return EXC_RESET;
    endcase
  endfunction
endpackage

// File: rtl/exc_pend_latch.sv
`timescale 1ns/1ps
module exc_pend_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] eff
);
  assign eff = pend | req;

  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[g] <= 1'b0;
      else        pend[g] <= (pend[g] | req[g]) & ~clr[g];
    end

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !clr[g]) |=> pend[g]); // R5
  end
endmodule

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter #(
  parameter int N = 7
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]     = cand[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | cand[g];
  end

  assign any = blocked[N];
endmodule

// File: rtl/exc_mask_track.sv
`timescale 1ns/1ps
module exc_mask_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take_fiq,
  input  logic take_irq,
  input  logic fiq_ret,
  input  logic irq_ret,
  input  logic fiq_reen,
  input  logic irq_reen,
  output logic fiq_off,
  output logic irq_off
);
  logic irq_saved;
  logic fiq_nx, irq_nx, saved_nx;

  always_comb begin
    fiq_nx   = fiq_off;
    irq_nx   = irq_off;
    saved_nx = irq_saved;
    if (fiq_ret) begin
      fiq_nx = 1'b0;
      irq_nx = irq_saved;
    end
    if (fiq_reen)           fiq_nx = 1'b0;
    if (irq_ret || irq_reen) irq_nx = 1'b0;
    if (take_fiq) begin
      saved_nx = irq_off;
      fiq_nx   = 1'b1;
      irq_nx   = 1'b1;
    end
    if (take_irq) irq_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_off   <= 1'b0;
      irq_off   <= 1'b0;
      irq_saved <= 1'b0;
    end else begin
      fiq_off   <= fiq_nx;
      irq_off   <= irq_nx;
      irq_saved <= saved_nx;
    end
  end

  AST_FIQ_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    take_fiq |=> (fiq_off && irq_off)); // R6
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> irq_off); // R7
  AST_NO_DOUBLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_fiq && take_irq)); // R2
endmodule

// File: rtl/exc_vector_sel.sv
`timescale 1ns/1ps
module exc_vector_sel
  import exc_sel_pkg::*;
#(
  parameter int              VEC_W     = 32,
  parameter logic [VEC_W-1:0] HIGH_BASE = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_high_vec,
  input  logic             i_req_dabort,
  input  logic             i_req_fiq,
  input  logic             i_req_irq,
  input  logic             i_req_pabort,
  input  logic             i_req_undef,
  input  logic             i_req_swi,
  input  logic             i_fiq_ret,
  input  logic             i_irq_ret,
  input  logic             i_fiq_reen,
  input  logic             i_irq_reen,
  output logic             o_take,
  output logic [CODE_W-1:0] o_code,
  output logic [VEC_W-1:0] o_vec,
  output logic             o_fiq_off,
  output logic             o_irq_off
);
  localparam int VSHIFT = 2;   // vector slot spacing in bytes is 1 << VSHIFT

  logic              boot_q;
  logic [NPULSE-1:0] p_req, p_clr, p_pend, p_eff;
  logic [NSRC-1:0]   cand, grant;
  logic              any;
  logic              fiq_off, irq_off;
  exc_code_e         sel_code;
  logic [VEC_W-1:0]  sel_vec;

  // Pulse lanes
  assign p_req[PL_DABORT] = i_req_dabort;
  assign p_req[PL_PABORT] = i_req_pabort;
  assign p_req[PL_UNDEF]  = i_req_undef;
  assign p_req[PL_SWI]    = i_req_swi;

  assign p_clr[PL_DABORT] = grant[SLOT_DABORT];
  assign p_clr[PL_PABORT] = grant[SLOT_PABORT];
  assign p_clr[PL_UNDEF]  = grant[SLOT_UNDEF];
  assign p_clr[PL_SWI]    = grant[SLOT_SWI];

  exc_pend_latch #(.N(NPULSE)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (p_req),
    .clr  (p_clr),
    .pend (p_pend),
    .eff  (p_eff)
  );

  // Candidates in priority order
  assign cand[SLOT_RESET]  = boot_q;
  assign cand[SLOT_DABORT] = p_eff[PL_DABORT];
  assign cand[SLOT_FIQ]    = i_req_fiq & ~fiq_off;
  assign cand[SLOT_IRQ]    = i_req_irq & ~irq_off & ~fiq_off;
  assign cand[SLOT_PABORT] = p_eff[PL_PABORT];
  assign cand[SLOT_UNDEF]  = p_eff[PL_UNDEF];
  assign cand[SLOT_SWI]    = p_eff[PL_SWI];

  exc_arbiter #(.N(NSRC)) u_arb (
    .cand (cand),
    .grant(grant),
    .any  (any)
  );

  exc_mask_track u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_fiq(grant[SLOT_FIQ]),
    .take_irq(grant[SLOT_IRQ]),
    .fiq_ret (i_fiq_ret),
    .irq_ret (i_irq_ret),
    .fiq_reen(i_fiq_reen),
    .irq_reen(i_irq_reen),
    .fiq_off (fiq_off),
    .irq_off (irq_off)
  );

  // Code and vector of the winner
  always_comb begin
    sel_code = EXC_RESET;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) sel_code = slot_code(i);
    end
  end

  always_comb begin
    sel_vec = VEC_W'(sel_code) << VSHIFT;
    if (i_high_vec && sel_code != EXC_RESET) sel_vec = sel_vec + HIGH_BASE;
  end

  // Boot event and registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      o_take <= 1'b0;
      o_code <= '0;
      o_vec  <= '0;
    end else begin
      if (grant[SLOT_RESET]) boot_q <= 1'b0;
      o_take <= any;
      o_code <= any ? sel_code : EXC_RESET;
      o_vec  <= any ? sel_vec : '0;
    end
  end

  assign o_fiq_off = fiq_off;
  assign o_irq_off = irq_off;

  AST_UNDEF_SWI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(i_req_undef && i_req_swi)); // R9
  AST_RESET_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (o_take && o_code == EXC_RESET) |-> (o_vec == '0)); // R1
  AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (o_take && o_code == EXC_IRQ) |-> !($past(irq_off) || $past(fiq_off))); // R6
  AST_HIGH_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_take && o_code != EXC_RESET && $past(i_high_vec)) |-> (o_vec[VEC_W-1:16] == HIGH_BASE[VEC_W-1:16])); // R4
  AST_FIQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_take && o_code == EXC_FIQ) |=> !(o_take && o_code == EXC_FIQ)); // R8
  AST_IRQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_take && o_code == EXC_IRQ) |=> !(o_take && o_code == EXC_IRQ)); // R8
endmodule

// File: tb/sim_exc_vector_sel.sv
`timescale 1ns/1ps
module sim_exc_vector_sel;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_high_vec = 1'b0;
  logic        i_req_dabort = 1'b0, i_req_fiq = 1'b0, i_req_irq = 1'b0;
  logic        i_req_pabort = 1'b0, i_req_undef = 1'b0, i_req_swi = 1'b0;
  logic        i_fiq_ret = 1'b0, i_irq_ret = 1'b0, i_fiq_reen = 1'b0, i_irq_reen = 1'b0;
  logic        o_take;
  logic [2:0]  o_code;
  logic [31:0] o_vec;
  logic        o_fiq_off, o_irq_off;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  exc_vector_sel u0 (
    .clk(clk), .rst_n(rst_n), .i_high_vec(i_high_vec),
    .i_req_dabort(i_req_dabort), .i_req_fiq(i_req_fiq), .i_req_irq(i_req_irq),
    .i_req_pabort(i_req_pabort), .i_req_undef(i_req_undef), .i_req_swi(i_req_swi),
    .i_fiq_ret(i_fiq_ret), .i_irq_ret(i_irq_ret), .i_fiq_reen(i_fiq_reen),
    .i_irq_reen(i_irq_reen), .o_take(o_take), .o_code(o_code), .o_vec(o_vec),
    .o_fiq_off(o_fiq_off), .o_irq_off(o_irq_off)
  );

  function automatic logic [31:0] exp_vec(input int code, input logic hv);
    if (code == 0) return 32'h0;
    return (hv ? 32'hFFFF_0000 : 32'h0) + 32'(code * 4);
  endfunction

  task automatic chk(input string tag, input logic t, input int code, input logic hv);
    logic [31:0] ev;
    ev = exp_vec(code, hv);
    n_chk++;
    if (o_take !== t || (t && (o_code !== 3'(code) || o_vec !== ev))) begin
      n_err++;
      $display("FAIL %s: take/code/vec=%0b/%0d/%h expected %0b/%0d/%h",
               tag, o_take, o_code, o_vec, t, code, ev);
    end
  endtask

  task automatic chk_flags(input string tag, input logic f, input logic i);
    n_chk++;
    if (o_fiq_off !== f || o_irq_off !== i) begin
      n_err++;
      $display("FAIL %s: fiq_off/irq_off=%0b/%0b expected %0b/%0b",
               tag, o_fiq_off, o_irq_off, f, i);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic hv);
    {i_req_dabort, i_req_fiq, i_req_irq, i_req_pabort, i_req_undef, i_req_swi} = '0;
    {i_fiq_ret, i_irq_ret, i_fiq_reen, i_irq_reen} = '0;
    i_high_vec = hv;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 held in reset", 1'b0, 0, hv);
    rst_n = 1'b1;
    tick;
    chk("R1 R4 boot take", 1'b1, 0, hv);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R10: run did not finish, expected completion");
      summary;
      $finish;
    end
  end

  initial begin
    int codes[6];
    int n;
    @(negedge clk);

    // Sweep: all legal one-cycle request mixes under both vector bases
    for (int hv = 0; hv < 2; hv++) begin
      for (int m = 0; m < 64; m++) begin
        if (m[4] && m[5]) continue;
        do_reset(hv[0]);
        n = 0;
        if (m[0]) codes[n++] = 4;
        if (m[1]) codes[n++] = 7;
        if (m[2] && !m[1]) codes[n++] = 6;
        if (m[3]) codes[n++] = 3;
        if (m[4]) codes[n++] = 1;
        if (m[5]) codes[n++] = 2;
        i_req_dabort = m[0]; i_req_fiq = m[1]; i_req_irq = m[2];
        i_req_pabort = m[3]; i_req_undef = m[4]; i_req_swi = m[5];
        tick;
        i_req_dabort = 0; i_req_pabort = 0; i_req_undef = 0; i_req_swi = 0;
        if (n == 0) chk("R2 R10 idle", 1'b0, 0, hv[0]);
        for (int k = 0; k < n; k++) begin
          if (k > 0) tick;
          chk(hv[0] ? "R2 R3 R4 R5 R10 order" : "R2 R3 R5 R10 order", 1'b1, codes[k], hv[0]);
        end
        tick;
        chk("R8 no retake", 1'b0, 0, hv[0]);
        chk_flags("R6 R7 flags after sweep", m[1], m[1] | m[2]);
        i_req_fiq = 0; i_req_irq = 0;
      end
    end

    // Flag restore when normal flag was set before the fast take
    do_reset(1'b0);
    i_req_irq = 1; tick; i_req_irq = 0;
    chk("R7 irq take", 1'b1, 6, 1'b0);
    chk_flags("R7 irq sets only its flag", 1'b0, 1'b1);
    i_req_fiq = 1; tick; i_req_fiq = 0;
    chk("R6 fiq take", 1'b1, 7, 1'b0);
    chk_flags("R6 fiq sets both", 1'b1, 1'b1);
    i_fiq_ret = 1; tick; i_fiq_ret = 0;
    chk_flags("R6 restore set flag", 1'b0, 1'b1);
    i_req_irq = 1; tick;
    chk("R6 R7 irq blocked", 1'b0, 0, 1'b0);
    i_irq_ret = 1; tick; i_irq_ret = 0;
    chk("R7 clear edge no take", 1'b0, 0, 1'b0);
    tick;
    chk("R7 irq after return", 1'b1, 6, 1'b0);
    i_req_irq = 0;

    // Flag restore when normal flag was clear
    do_reset(1'b1);
    i_req_fiq = 1; tick; i_req_fiq = 0;
    chk("R4 R6 fiq high vec", 1'b1, 7, 1'b1);
    i_req_irq = 1; tick;
    chk("R6 irq masked in fiq", 1'b0, 0, 1'b1);
    i_fiq_ret = 1; tick; i_fiq_ret = 0;
    chk_flags("R6 restore clear flag", 1'b0, 1'b0);
    tick;
    chk("R6 irq after fiq return", 1'b1, 6, 1'b1);
    i_req_irq = 0;

    // Re-enable inputs with a held line
    do_reset(1'b0);
    i_req_fiq = 1; tick;
    chk("R8 fiq first", 1'b1, 7, 1'b0);
    tick;
    chk("R8 fiq held not retaken", 1'b0, 0, 1'b0);
    i_fiq_reen = 1; tick; i_fiq_reen = 0;
    chk_flags("R7 fiq reenable", 1'b0, 1'b1);
    tick;
    chk("R7 R8 fiq taken again", 1'b1, 7, 1'b0);
    i_req_fiq = 0;
    i_fiq_reen = 1; i_irq_reen = 1; tick; i_fiq_reen = 0; i_irq_reen = 0;
    chk_flags("R7 both reenabled", 1'b0, 1'b0);
    i_req_irq = 1; tick;
    chk("R8 irq once", 1'b1, 6, 1'b0);
    i_irq_reen = 1; tick; i_irq_reen = 0;
    chk("R8 irq waits", 1'b0, 0, 1'b0);
    tick;
    chk("R7 R8 irq after reenable", 1'b1, 6, 1'b0);
    i_req_irq = 0;

    // Undefined and software interrupt in consecutive cycles, and both pending
    do_reset(1'b0);
    i_req_undef = 1; tick; i_req_undef = 0; i_req_swi = 1;
    chk("R9 undef first", 1'b1, 1, 1'b0);
    tick; i_req_swi = 0;
    chk("R9 swi next", 1'b1, 2, 1'b0);
    i_req_dabort = 1; i_req_swi = 1; tick;
    i_req_dabort = 0; i_req_swi = 0; i_req_undef = 1;
    chk("R2 R5 dabort wins", 1'b1, 4, 1'b0);
    tick; i_req_undef = 0;
    chk("R5 R9 undef before pending swi", 1'b1, 1, 1'b0);
    tick;
    chk("R5 pending swi", 1'b1, 2, 1'b0);
    tick;
    chk("R5 drained", 1'b0, 0, 1'b0);

    // Asynchronous reset while flags are set
    i_req_fiq = 1; tick; i_req_fiq = 0;
    chk_flags("R6 flags before async reset", 1'b1, 1'b1);
    #5 rst_n = 1'b0;
    #1;
    chk("R1 async clear take", 1'b0, 0, 1'b0);
    chk_flags("R1 async clear flags", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tick;
    chk("R1 boot after async reset", 1'b1, 0, 1'b0);

    done = 1'b1;
    summary;
    $finish;
  end
endmodule